// File: doc/BRIEF.md
# Li-ion Charge Control Sequencer

This block is the digital controller of a single-cell linear charger. It reads condition flags produced by the analog front end: supply present, charger enable, safety-timer enable, battery below the minimum level, battery at the regulation voltage, current below the termination level, battery below the recharge level, pack temperature out of window, and pack absent. From these flags it walks a battery through conditioning, full-current charging and voltage regulation. It then rests in a completed state until the cell needs topping up again.

The block drives a two-bit mode select to the analog loop and two active-low indications. A safety timer advances on a single-cycle tick taken from the charger oscillator. It bounds the time spent in conditioning and the time spent in fast charge. A timer expiry latches until the enable input is cycled or the supply is lost and restored. A temperature fault or a missing pack stops charging, and a fresh cycle starts on its own once the condition clears. A test input shortens the timer so that both limits can be reached in a short run. Every flag except the tick passes through a two-flop synchronizer, so a flag change reaches the outputs on the third clock edge.

Top module: `chg_seq_top`

## Requirements
- R1: After a reset, and again when the supply returns after a loss, the block holds a power-up interval of POR_CYCLES clocks with faultN=0, statusN=1 and chargeMode=2'b00.
- R2: Every charge cycle starts in conditioning, chargeMode=2'b01. In any charging mode statusN=0 and faultN=1. The mode encodings are 2'b01 conditioning (one-tenth reference), 2'b10 full reference, 2'b11 voltage regulation and 2'b00 off.
- R3: Conditioning moves to full current (2'b10) only after QUAL_TICKS (15) consecutive ticks on which vbatLow is low. A tick with vbatLow high restarts the count.
- R4: If conditioning lasts one eighth of the full timeout in ticks, a timeout fault is raised. This happens whatever the level of timerEn.
- R5: The timer clears on entry to full current. With timerEn high, a fault is raised when full-current time plus regulation time reaches the full timeout. With timerEn low, no such fault is raised.
- R6: Full current moves to regulation (2'b11) when vbatReg is high. Regulation moves to the completed state when iTerm is high. The completed state shows statusN=1, faultN=1 and mode 2'b00.
- R7: In the completed state, vbatRech high starts a new conditioning phase. Ticks do not advance the timer in the completed state.
- R8: A timeout fault is latched. It ignores all charging flags and clears only after enable goes low and then high, or after the supply is lost and restored.
- R9: tempFault or batMissing during charging or in the completed state gives faultN=0, statusN=1 and mode off. Conditioning restarts by itself once both flags are low.
- R10: When enable or supplyOk is low (outside the power-up interval), the block is in standby with statusN=1, faultN=1 and mode off.
- R11: The full timeout is 2^TIMER_STAGES ticks. When testMode is high it is 2^(TIMER_STAGES-TEST_SHIFT) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, equivalent to power-up |
| tick | input | 1 | One-clock pulse per oscillator period (synchronous) |
| testMode | input | 1 | Shortens the safety timer |
| supplyOk | input | 1 | Input supply above threshold (asynchronous) |
| enable | input | 1 | Charger enable (asynchronous) |
| timerEn | input | 1 | Enables the fast-charge timeout (asynchronous) |
| vbatLow | input | 1 | Battery below the conditioning threshold (asynchronous) |
| vbatReg | input | 1 | Battery at the regulation voltage (asynchronous) |
| iTerm | input | 1 | Charge current below the termination level (asynchronous) |
| vbatRech | input | 1 | Battery below the recharge threshold (asynchronous) |
| tempFault | input | 1 | Pack temperature outside its window (asynchronous) |
| batMissing | input | 1 | Pack removed (asynchronous) |
| chargeMode | output | 2 | Analog loop mode select |
| statusN | output | 1 | Active-low charging indication |
| faultN | output | 1 | Active-low fault indication |

## Verification
A wrong internal state shows up at once on the indication pair and the mode select. Both decode directly from the state register, so a bad transition appears on the clock edge after the synchronized flag that caused it. Timer or qualification counts that run off by one move a mode change by exactly one tick, so the bench samples at the last tick before each limit and at the limit itself. A latch that releases early shows up as charging resuming while enable stays high.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_STBY,
    ST_TRKL,
    ST_FULL,
    ST_REG,
    ST_DONE,
    ST_TFLT,
    ST_TOUT
  } chgState_t;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_TRKL = 2'b01,
    MODE_FULL = 2'b10,
    MODE_REG  = 2'b11
  } chgMode_t;

  // strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic clrTimer;
    logic runTimer;
    logic clrQual;
    logic runQual;
  } tmrCtl_t;

  // status returned by the timer datapath
  typedef struct packed {
    logic qualDone;
    logic trickleOver;
    logic fullOver;
  } tmrFlags_t;

  localparam int NUM_FLAGS = 9;
  localparam int IDX_SUP   = 0;
  localparam int IDX_EN    = 1;
  localparam int IDX_TEN   = 2;
  localparam int IDX_VLOW  = 3;
  localparam int IDX_VREG  = 4;
  localparam int IDX_ITRM  = 5;
  localparam int IDX_RECH  = 6;
  localparam int IDX_TEMP  = 7;
  localparam int IDX_MISS  = 8;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[g] <= '0;
      end else if (g == 0) begin
        stage[g] <= dIn;
      end else begin
        stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/chg_timer.sv
module chg_timer
  import chg_pkg::*;
#(
  parameter int TIMER_STAGES = 22,
  parameter int TEST_SHIFT   = 12,
  parameter int QUAL_TICKS   = 15
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      testMode,
  input  logic      belowMin,
  input  tmrCtl_t   ctl,
  output tmrFlags_t flags
);

  localparam int CNT_W = TIMER_STAGES + 1;
  localparam int QW    = $clog2(QUAL_TICKS + 1);
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LIM_NORM = ONE << TIMER_STAGES;
  localparam logic [CNT_W-1:0] LIM_TEST = ONE << (TIMER_STAGES - TEST_SHIFT);
  localparam logic [QW-1:0]    QUAL_MAX = QW'(QUAL_TICKS);

  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] fullLimit;
  logic [CNT_W-1:0] trickleLimit;
  logic [QW-1:0]    qualCnt;

  assign fullLimit    = testMode ? LIM_TEST : LIM_NORM;
  assign trickleLimit = fullLimit >> 3;

  // safety timer: saturates at the full limit
  always_ff @(posedge clk) begin
    if (rst || ctl.clrTimer) begin
      elapsed <= '0;
    end else if (ctl.runTimer && tick && (elapsed < fullLimit)) begin
      elapsed <= elapsed + ONE;
    end
  end

  // consecutive-tick qualifier for leaving conditioning
  always_ff @(posedge clk) begin
    if (rst || ctl.clrQual) begin
      qualCnt <= '0;
    end else if (ctl.runQual && tick) begin
      if (belowMin) begin
        qualCnt <= '0;
      end else if (qualCnt != QUAL_MAX) begin
        qualCnt <= qualCnt + 1'b1;
      end
    end
  end

  assign flags.qualDone    = (qualCnt == QUAL_MAX);
  assign flags.trickleOver = (elapsed >= trickleLimit);
  assign flags.fullOver    = (elapsed >= fullLimit);

endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
#(
  parameter int POR_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flagsS,
  input  tmrFlags_t            tmr,
  output tmrCtl_t              ctl,
  output chgState_t            curState,
  output logic [1:0]           chargeMode,
  output logic                 statusN,
  output logic                 faultN
);

  localparam int PW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
  localparam logic [PW-1:0] POR_LAST = PW'(POR_CYCLES - 1);

  chgState_t     state, nxt;
  logic [PW-1:0] porCnt;
  logic          porPend;
  logic          porDone;

  logic sup, en, ten, vReg, iTrm, rech, hot, miss;
  assign sup  = flagsS[IDX_SUP];
  assign en   = flagsS[IDX_EN];
  assign ten  = flagsS[IDX_TEN];
  assign vReg = flagsS[IDX_VREG];
  assign iTrm = flagsS[IDX_ITRM];
  assign rech = flagsS[IDX_RECH];
  assign hot  = flagsS[IDX_TEMP];
  assign miss = flagsS[IDX_MISS];

  assign porDone = (porCnt == POR_LAST);

  always_comb begin
    nxt = state;
    if (state == ST_POR) begin
      if (porDone) nxt = (sup && en) ? ST_TRKL : ST_STBY;
    end else if (!sup) begin
      nxt = ST_STBY;
    end else if (porPend) begin
      nxt = ST_POR;
    end else if (!en) begin
      nxt = ST_STBY;
    end else begin
      unique case (state)
        ST_STBY: nxt = ST_TRKL;
        ST_TOUT: nxt = ST_TOUT;
        ST_TFLT: if (!hot && !miss) nxt = ST_TRKL;
        ST_TRKL: begin
          if (hot || miss)          nxt = ST_TFLT;
          else if (tmr.trickleOver) nxt = ST_TOUT;
          else if (tmr.qualDone)    nxt = ST_FULL;
        end
        ST_FULL: begin
          if (hot || miss)              nxt = ST_TFLT;
          else if (ten && tmr.fullOver) nxt = ST_TOUT;
          else if (vReg)                nxt = ST_REG;
        end
        ST_REG: begin
          if (hot || miss)              nxt = ST_TFLT;
          else if (ten && tmr.fullOver) nxt = ST_TOUT;
          else if (iTrm)                nxt = ST_DONE;
        end
        ST_DONE: begin
          if (hot || miss) nxt = ST_TFLT;
          else if (rech)   nxt = ST_TRKL;
        end
        default: nxt = ST_STBY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_POR;
    end else begin
      state <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_POR) begin
      porCnt <= '0;
    end else if (!porDone) begin
      porCnt <= porCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sup) begin
      porPend <= 1'b1;
    end else if (state == ST_POR) begin
      porPend <= 1'b0;
    end
  end

  always_comb begin
    ctl.clrQual  = (nxt == ST_TRKL) && (state != ST_TRKL);
    ctl.clrTimer = ctl.clrQual || ((nxt == ST_FULL) && (state != ST_FULL));
    ctl.runTimer = (state == ST_TRKL) || (state == ST_FULL) || (state == ST_REG);
    ctl.runQual  = (state == ST_TRKL);
  end

  always_comb begin
    chgMode_t m;
    m       = MODE_OFF;
    statusN = 1'b1;
    faultN  = 1'b1;
    unique case (state)
      ST_TRKL: begin m = MODE_TRKL; statusN = 1'b0; end
      ST_FULL: begin m = MODE_FULL; statusN = 1'b0; end
      ST_REG:  begin m = MODE_REG;  statusN = 1'b0; end
      ST_POR, ST_TFLT, ST_TOUT: faultN = 1'b0;
      default: ;
    endcase
    chargeMode = m;
  end

  assign curState = state;

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_pkg::*;
#(
  parameter int TIMER_STAGES = 22,
  parameter int TEST_SHIFT   = 12,
  parameter int QUAL_TICKS   = 15,
  parameter int POR_CYCLES   = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       testMode,
  input  logic       supplyOk,
  input  logic       enable,
  input  logic       timerEn,
  input  logic       vbatLow,
  input  logic       vbatReg,
  input  logic       iTerm,
  input  logic       vbatRech,
  input  logic       tempFault,
  input  logic       batMissing,
  output logic [1:0] chargeMode,
  output logic       statusN,
  output logic       faultN
);

  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] syncFlags;
  tmrCtl_t              tmrCtl;
  tmrFlags_t            tmrFlags;
  chgState_t            curState;
  logic                 supSync;
  logic                 enSync;

  assign rawFlags = {batMissing, tempFault, vbatRech, iTerm, vbatReg,
                     vbatLow, timerEn, enable, supplyOk};

  chg_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .dIn (rawFlags),
    .dOut(syncFlags)
  );

  chg_timer #(
    .TIMER_STAGES(TIMER_STAGES),
    .TEST_SHIFT  (TEST_SHIFT),
    .QUAL_TICKS  (QUAL_TICKS)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .testMode(testMode),
    .belowMin(syncFlags[IDX_VLOW]),
    .ctl     (tmrCtl),
    .flags   (tmrFlags)
  );

  chg_ctrl #(.POR_CYCLES(POR_CYCLES)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .flagsS    (syncFlags),
    .tmr       (tmrFlags),
    .ctl       (tmrCtl),
    .curState  (curState),
    .chargeMode(chargeMode),
    .statusN   (statusN),
    .faultN    (faultN)
  );

  assign supSync = syncFlags[IDX_SUP];
  assign enSync  = syncFlags[IDX_EN];

endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk
  import chg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] chargeMode,
  input logic       statusN,
  input logic       faultN,
  input logic       supSync,
  input logic       enSync,
  input chgState_t  curState
);

  // R2: any charging mode shows the charging indication
  p_charge_indic_r2: assert property (@(posedge clk) disable iff (rst)
    (chargeMode != 2'b00) |-> (!statusN && faultN));

  // R9: a fault indication never coexists with an active loop
  p_fault_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!faultN) |-> (chargeMode == 2'b00 && statusN));

  // R3: full current is only ever entered from conditioning
  p_full_from_trkl_r3: assert property (@(posedge clk) disable iff (rst)
    (chargeMode == 2'b10 && $past(chargeMode) != 2'b10) |-> ($past(chargeMode) == 2'b01));

  // R6: regulation is only ever entered from full current
  p_reg_from_full_r6: assert property (@(posedge clk) disable iff (rst)
    (chargeMode == 2'b11 && $past(chargeMode) != 2'b11) |-> ($past(chargeMode) == 2'b10));

  // R10: losing supply or enable turns the loop off on the next edge
  p_standby_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!supSync || !enSync) |=> (chargeMode == 2'b00));

  // R8: the timeout latch holds while supply and enable stay high
  p_tout_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_TOUT && supSync && enSync) |=> (curState == ST_TOUT));

endmodule

bind chg_seq_top chg_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .chargeMode(chargeMode),
  .statusN   (statusN),
  .faultN    (faultN),
  .supSync   (supSync),
  .enSync    (enSync),
  .curState  (curState)
);

// File: tb/chg_seq_top_tb.sv
module chg_seq_top_tb_top;

  localparam int K_IDLE  = 0;
  localparam int K_TRKL  = 1;
  localparam int K_FULL  = 2;
  localparam int K_REG   = 3;
  localparam int K_FAULT = 4;
  localparam int K_POR   = 5;
  localparam int FULL_TEST = 1 << (22 - 12);
  localparam int TRKL_TEST = FULL_TEST / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, testMode = 1'b1;
  logic supplyOk = 1'b1, enable = 1'b1, timerEn = 1'b0;
  logic vbatLow = 1'b0, vbatReg = 1'b0, iTerm = 1'b0, vbatRech = 1'b0;
  logic tempFault = 1'b0, batMissing = 1'b0;
  logic [1:0] chargeMode;
  logic statusN, faultN;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  chg_seq_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .testMode(testMode),
    .supplyOk(supplyOk), .enable(enable), .timerEn(timerEn),
    .vbatLow(vbatLow), .vbatReg(vbatReg), .iTerm(iTerm), .vbatRech(vbatRech),
    .tempFault(tempFault), .batMissing(batMissing),
    .chargeMode(chargeMode), .statusN(statusN), .faultN(faultN)
  );

  // expected {mode, statusN, faultN} per situation, from the requirements
  function automatic logic [3:0] expIndic(int kind);
    case (kind)
      K_TRKL:  return {2'b01, 1'b0, 1'b1};
      K_FULL:  return {2'b10, 1'b0, 1'b1};
      K_REG:   return {2'b11, 1'b0, 1'b1};
      K_FAULT: return {2'b00, 1'b1, 1'b0};
      K_POR:   return {2'b00, 1'b1, 1'b0};
      default: return {2'b00, 1'b1, 1'b1};
    endcase
  endfunction

  task automatic check(string req, int kind);
    logic [3:0] act, exp;
    act = {chargeMode, statusN, faultN};
    exp = expIndic(kind);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {mode,statusN,faultN} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doTick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      settle(2);
    end
  endtask

  task automatic qualify();
    vbatLow = 1'b0;
    settle(4);
    doTick(15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int run;
    int ccTicks;
    void'($urandom(32'd4711));
    settle(4);
    rst = 1'b0;
    settle(2);
    check("R1 power-up interval after reset", K_POR);
    settle(12);
    check("R2 cycle starts in conditioning", K_TRKL);

    // R3: directed corner, 14 good ticks then a glitch, then random
    doTick(14);
    check("R3 14 ticks not enough", K_TRKL);
    vbatLow = 1'b1; settle(4); doTick(1);
    check("R3 glitch restarts count", K_TRKL);
    run = 0;
    for (int it = 0; it < 200 && run < 15; it++) begin
      vbatLow = (it < 60) && (($urandom % 8) == 0);
      settle(4);
      doTick(1);
      run = vbatLow ? 0 : run + 1;
      check("R3 random qualification", (run >= 15) ? K_FULL : K_TRKL);
    end

    // R5/R6: timer cleared at full-current entry, counts through regulation
    timerEn = 1'b1;
    settle(4);
    ccTicks = 100 + int'($urandom % 400);
    doTick(ccTicks);
    check("R5 full current before limit", K_FULL);
    vbatReg = 1'b1; settle(4);
    check("R6 full to regulation", K_REG);
    doTick(FULL_TEST - 1 - ccTicks);
    check("R5 one tick short of full timeout", K_REG);
    doTick(1);
    check("R5 full timeout fault", K_FAULT);

    // R8 release by enable toggle
    enable = 1'b0; settle(5);
    check("R10 standby on enable low", K_IDLE);
    vbatReg = 1'b0; enable = 1'b1; settle(5);
    check("R8 enable toggle releases latch", K_TRKL);

    // R4: conditioning limit applies with timerEn low
    timerEn = 1'b0; vbatLow = 1'b1; settle(4);
    doTick(TRKL_TEST - 1);
    check("R4 conditioning one tick short", K_TRKL);
    doTick(1);
    check("R4 conditioning limit fault with timerEn low", K_FAULT);
    vbatLow = 1'b0; vbatReg = 1'b1; iTerm = 1'b1; vbatRech = 1'b1;
    settle(4); doTick(20);
    check("R8 latch ignores charging flags", K_FAULT);
    tempFault = 1'b1; settle(5); tempFault = 1'b0; settle(5);
    check("R8 latch survives temperature event", K_FAULT);
    vbatReg = 1'b0; iTerm = 1'b0; vbatRech = 1'b0;
    enable = 1'b0; settle(5); enable = 1'b1; settle(5);
    check("R8 restart after toggle", K_TRKL);

    // R5: timerEn low lets fast charge exceed the timeout
    qualify();
    check("R3 clean qualification", K_FULL);
    doTick(FULL_TEST + 80);
    check("R5 no timeout with timerEn low", K_FULL);
    vbatReg = 1'b1; settle(4);
    check("R6 regulation entered", K_REG);
    iTerm = 1'b1; settle(4);
    check("R6 completed state", K_IDLE);
    vbatReg = 1'b0; iTerm = 1'b0; settle(4);
    doTick(8);
    check("R7 completed state holds without recharge", K_IDLE);
    vbatRech = 1'b1; settle(4);
    check("R7 recharge starts conditioning", K_TRKL);
    vbatRech = 1'b0;

    // R9: temperature fault and pack removal auto-restart
    qualify();
    tempFault = 1'b1; settle(4);
    check("R9 temperature fault stops charging", K_FAULT);
    tempFault = 1'b0; settle(4);
    check("R9 auto-restart after temperature", K_TRKL);
    batMissing = 1'b1; settle(4);
    check("R9 pack removal fault", K_FAULT);
    batMissing = 1'b0; settle(4);
    check("R9 restart on insertion", K_TRKL);

    // R11: normal timer length far exceeds the test length
    testMode = 1'b0; timerEn = 1'b1;
    qualify();
    doTick(FULL_TEST + 80);
    check("R11 normal mode timeout not reached", K_FULL);

    // R1/R10: supply loss and return
    supplyOk = 1'b0; settle(4);
    check("R10 standby on supply loss", K_IDLE);
    supplyOk = 1'b1; settle(4);
    check("R1 power-up interval after supply return", K_POR);
    settle(12);
    check("R2 conditioning after power-up", K_TRKL);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule